// File: doc/BRIEF.md
# Step-Rate Clock Generator

This block derives every timing strobe a stepper motor controller needs from a single system clock. It makes three signals: a periodic sampling strobe that paces button evaluation, a reference square wave, and a step-enable strobe whose rate is picked from a binary division chain below the reference. The chain yields rates from one half of the reference frequency down to 1/4096 of it, each option half the one before.

The system clock does not have to be an integer multiple of the reference frequency. A phase accumulator adds twice the reference frequency every cycle, modulo the clock frequency, and toggles the wave on each wrap. Over any window of one second the wave therefore holds the exact edge count. With the default parameters (12 MHz clock, 2048 Hz reference, 10 ms sampling period) rate code 0 gives 1024 Hz and rate code 11 gives 0.5 Hz.

All outputs are registered and stay in the system clock domain. The strobes are one cycle wide and are meant as clock enables for the phase sequencer and the button logic, never as clocks.

Top module: `step_rate_gen`

## Requirements
- R1: `tick_o` is high for exactly one cycle. Its first pulse follows the DIV-th rising clock edge after reset release, where DIV = CLK_HZ/TICK_HZ. After that it pulses every DIV cycles.
- R2: Starting from reset release, any window of CLK_HZ consecutive cycles holds exactly REF_HZ rising edges of `ref_o`.
- R3: After the first toggle, every high phase and every low phase of `ref_o` lasts either floor or ceil of CLK_HZ/(2*REF_HZ) cycles.
- R4: For rate code k (0 <= k < STAGES), `step_o` first pulses on the 2^k-th rising edge of `ref_o` after reset. After that it pulses on every 2^(k+1)-th rising edge. Each pulse occurs in the same cycle that `ref_o` goes high.
- R5: `step_o` is never high in two consecutive cycles.
- R6: A rate code of STAGES or above produces no `step_o` pulse.
- R7: While `rst_ni` is low, all outputs are low. Reset in the middle of operation restarts every counter and the accumulator, so the timing of R1 and R4 holds again from the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | SEL_W | Step-rate code k; rate is REF_HZ/2^(k+1) |
| tick_o | output | 1 | One-cycle sampling strobe every CLK_HZ/TICK_HZ cycles |
| ref_o | output | 1 | Reference square wave at REF_HZ |
| step_o | output | 1 | One-cycle step-enable strobe at the selected rate |

## Verification
The checker verifies the following on every cycle:
- the exact spacing of the sampling strobe;
- the floor and ceiling bounds on each phase length of the reference wave;
- that a step strobe is one cycle wide and falls on a rising edge of the reference;
- that an out-of-range rate code yields no strobe.

The bench scenarios cover what needs a long count. One scenario shows that every one-second window holds the exact number of reference edges, so no fractional error builds up. Others check the number of reference edges before the first step pulse and between step pulses for several rate codes. They also compare cycle-exact step intervals against the accumulator period and confirm that a reset mid-run restarts the whole timing.

// File: rtl/srg_pkg.sv
package srg_pkg;
  // bits needed to hold the values 0 .. n-1
  function automatic int width_for(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/srg_tick_div.sv
module srg_tick_div #(
  parameter int DIV = 120000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = srg_pkg::width_for(DIV);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/srg_ref_synth.sv
module srg_ref_synth #(
  parameter int CLK_HZ = 12000000,
  parameter int REF_HZ = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ref_o,
  output logic rise_o
);
  localparam int INC = 2 * REF_HZ;  // two toggles per period
  localparam int AW  = srg_pkg::width_for(CLK_HZ) + 1;

  logic [AW-1:0] acc_q;
  logic [AW-1:0] sum;
  logic          wrap;

  assign sum    = acc_q + AW'(INC);
  assign wrap   = (sum >= AW'(CLK_HZ));
  assign rise_o = wrap & ~ref_o;  // ref goes high at this edge

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ref_o <= 1'b0;
    end else if (wrap) begin
      acc_q <= sum - AW'(CLK_HZ);
      ref_o <= ~ref_o;
    end else begin
      acc_q <= sum;
    end
  end
endmodule

// File: rtl/srg_rate_chain.sv
module srg_rate_chain #(
  parameter int STAGES = 12,
  parameter int SEL_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] rise;
  logic              hit;

  // bit k rises when its lower bits are all ones and it is zero
  for (genvar k = 0; k < STAGES; k++) begin : g_rise
    if (k == 0) begin : g_lsb
      assign rise[k] = adv_i & ~cnt_q[0];
    end else begin : g_up
      assign rise[k] = adv_i & ~cnt_q[k] & (&cnt_q[k-1:0]);
    end
  end

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < STAGES; k++) begin
      if (sel_i == SEL_W'(k)) hit = rise[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_o <= 1'b0;
    end else begin
      if (adv_i) cnt_q <= cnt_q + 1'b1;
      step_o <= hit;
    end
  end
endmodule

// File: rtl/step_rate_gen.sv
module step_rate_gen #(
  parameter int CLK_HZ  = 12000000,
  parameter int TICK_HZ = 100,
  parameter int REF_HZ  = 2048,
  parameter int STAGES  = 12,
  parameter int SEL_W   = $clog2(STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] rate_sel_i,
  output logic             tick_o,
  output logic             ref_o,
  output logic             step_o
);
  localparam int TICK_DIV = CLK_HZ / TICK_HZ;

  logic ref_rise;

  srg_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick_o)
  );

  srg_ref_synth #(.CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_o  (ref_o),
    .rise_o (ref_rise)
  );

  srg_rate_chain #(.STAGES(STAGES), .SEL_W(SEL_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (ref_rise),
    .sel_i  (rate_sel_i),
    .step_o (step_o)
  );
endmodule

// File: rtl/step_rate_chk.sv
module step_rate_chk #(
  parameter int CLK_HZ  = 12000000,
  parameter int TICK_HZ = 100,
  parameter int REF_HZ  = 2048,
  parameter int STAGES  = 12,
  parameter int SEL_W   = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] rate_sel_i,
  input logic             tick_o,
  input logic             ref_o,
  input logic             step_o
);
  localparam int DIV    = CLK_HZ / TICK_HZ;
  localparam int GW     = srg_pkg::width_for(DIV) + 2;
  localparam int RUNMIN = CLK_HZ / (2 * REF_HZ);
  localparam int RUNMAX = (CLK_HZ + 2 * REF_HZ - 1) / (2 * REF_HZ);
  localparam int RW     = srg_pkg::width_for(RUNMAX) + 2;

  logic [GW-1:0] gap_q;
  logic [RW-1:0] run_q;
  logic          ref_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      run_q <= '0;
      ref_d <= 1'b0;
    end else begin
      gap_q <= tick_o ? GW'(1) : gap_q + 1'b1;
      run_q <= (ref_o != ref_d) ? RW'(1) : run_q + 1'b1;
      ref_d <= ref_o;
    end
  end

  assert_tick_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (gap_q == GW'(DIV)));
  assert_tick_gap_max_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GW'(DIV));
  assert_ref_run_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(RUNMAX));
  assert_ref_run_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_o != ref_d) |-> (run_q >= RW'(RUNMIN)));
  assert_step_on_ref_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $rose(ref_o));
  assert_step_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
  assert_sel_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rate_sel_i) >= STAGES) |=> !step_o);
endmodule

bind step_rate_gen step_rate_chk #(
  .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .REF_HZ(REF_HZ), .STAGES(STAGES), .SEL_W(SEL_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rate_sel_i(rate_sel_i),
  .tick_o(tick_o), .ref_o(ref_o), .step_o(step_o)
);

// File: tb/sim_step_rate_gen.sv
`timescale 1ns/1ps
module sim_step_rate_gen;
  localparam int CLK_HZ  = 300;
  localparam int TICK_HZ = 25;
  localparam int REF_HZ  = 32;
  localparam int STAGES  = 12;
  localparam int SEL_W   = 4;
  localparam int DIV     = CLK_HZ / TICK_HZ;
  localparam int RUNMIN  = CLK_HZ / (2 * REF_HZ);
  localparam int RUNMAX  = (CLK_HZ + 2 * REF_HZ - 1) / (2 * REF_HZ);

  typedef struct packed {
    logic [3:0] sel;
    int         first;
    int         gap;
  } vec_t;

  // rate code, expected rises to first strobe (2^k), rises between strobes (2^(k+1))
  localparam vec_t VEC [0:6] = '{
    '{4'd0, 1, 2}, '{4'd1, 2, 4}, '{4'd2, 4, 8}, '{4'd3, 8, 16},
    '{4'd5, 32, 64}, '{4'd7, 128, 256}, '{4'd11, 2048, 4096}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [SEL_W-1:0] rate_sel_i = '0;
  logic             tick_o, ref_o, step_o;

  always #2.5 clk_i = ~clk_i;

  step_rate_gen #(
    .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .REF_HZ(REF_HZ), .STAGES(STAGES), .SEL_W(SEL_W)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_sel_i(rate_sel_i),
    .tick_o(tick_o), .ref_o(ref_o), .step_o(step_o)
  );

  int   checks = 0, errors = 0;
  int   cyc = 0, rise_cnt = 0, run_len = 0, bad_runs = 0;
  logic ref_prev = 1'b0;
  bit   ref_rise = 0, seen_toggle = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clk_step();
    @(posedge clk_i);
    #1;
    ref_rise = ref_o && !ref_prev;
    if (ref_rise) rise_cnt++;
    if (ref_o != ref_prev) begin
      if (seen_toggle && (run_len < RUNMIN || run_len > RUNMAX)) bad_runs++;
      seen_toggle = 1;
      run_len = 1;
    end else begin
      run_len++;
    end
    ref_prev = ref_o;
    cyc++;
  endtask

  task automatic apply_reset(input logic [SEL_W-1:0] sel);
    @(negedge clk_i);
    rst_ni = 1'b0;
    rate_sel_i = sel;
    repeat (3) @(negedge clk_i);
    check("R7 tick_o low in reset", int'(tick_o), 0);
    check("R7 ref_o low in reset", int'(ref_o), 0);
    check("R7 step_o low in reset", int'(step_o), 0);
    ref_prev = 1'b0;
    seen_toggle = 0;
    run_len = 0;
    bad_runs = 0;
    rst_ni = 1'b1;
  endtask

  task automatic wait_step();
    int guard = 0;
    do begin
      clk_step();
      guard++;
    end while (!step_o && guard < 100000);
  endtask

  initial begin
    int n, r0, c0, ex;

    // R7 + R1: first tick and steady spacing
    apply_reset('0);
    n = 0;
    do begin clk_step(); n++; end while (!tick_o && n < 1000);
    check("R1 first tick edge count", n, DIV);
    for (int i = 0; i < 3; i++) begin
      n = 0;
      do begin clk_step(); n++; end while (!tick_o && n < 1000);
      check("R1 tick spacing", n, DIV);
    end

    // R2 edge count per window, R3 phase lengths
    apply_reset('0);
    for (int w = 0; w < 3; w++) begin
      r0 = rise_cnt;
      repeat (CLK_HZ) clk_step();
      check("R2 ref rises per window", rise_cnt - r0, REF_HZ);
      check("R3 ref phase lengths out of bounds", bad_runs, 0);
    end

    // R4/R5 table walk
    for (int v = 0; v < 7; v++) begin
      apply_reset(SEL_W'(VEC[v].sel));
      r0 = rise_cnt;
      wait_step();
      check($sformatf("R4 sel=%0d rises to first step", VEC[v].sel), rise_cnt - r0, VEC[v].first);
      check("R4 step with ref rise", int'(ref_rise), 1);
      c0 = cyc;
      r0 = rise_cnt;
      clk_step();
      check("R5 step one cycle wide", int'(step_o), 0);
      wait_step();
      check($sformatf("R4 sel=%0d rises between steps", VEC[v].sel), rise_cnt - r0, VEC[v].gap);
      if ((VEC[v].gap * CLK_HZ) % REF_HZ == 0) begin
        ex = VEC[v].gap * CLK_HZ / REF_HZ;
        check($sformatf("R4 sel=%0d cycles between steps", VEC[v].sel), cyc - c0, ex);
      end
    end

    // R6 out-of-range codes
    apply_reset(SEL_W'(12));
    n = 0;
    repeat (1500) begin clk_step(); if (step_o) n++; end
    check("R6 code 12 step count", n, 0);
    rate_sel_i = SEL_W'(15);
    n = 0;
    repeat (1500) begin clk_step(); if (step_o) n++; end
    check("R6 code 15 step count", n, 0);

    // R7 reset in the middle of operation
    rate_sel_i = '0;
    repeat (57) clk_step();
    apply_reset('0);
    n = 0;
    r0 = rise_cnt;
    do begin
      clk_step();
      n++;
      if (step_o) check("R7 first step after restart", rise_cnt - r0, 1);
    end while (!tick_o && n < 1000);
    check("R7 tick restart edge count", n, DIV);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #975000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule